// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave end of a three- or four-wire serial link that gives a host access to a converter's register file. The host lowers an active-low select line and toggles a serial clock. It sends a command byte that names a register and picks a read or a write. It then shifts that register's contents in or out, most significant bit first. The single output pin carries read data during a read. At all other times it carries an active-low "result available" flag, so the falling edge of that pin can serve as an interrupt.

The controller runs on a fast system clock. The serial inputs are resynchronised, and their edges are found in that domain. Register storage, the ready source and the conversion engine sit outside the block. They are reached through a flat parallel port: an address, read data presented for the current address, write data with a one-cycle write strobe, a pulse when a result has been read out, and a pulse that asks the register file to return to its defaults.

Two extra features cover streaming and recovery. A continuous-read mode streams conversion results with no command byte. A long run of ones on the data input forces the whole interface back to its starting point.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the controller waits for a command byte. It raises no write strobe, result pulse or interface-reset pulse until the host clocks data in. The first command sent after select falls is decoded.
- R2: The command byte's most significant bit is a start bit. While it is sampled as 1, the bit position does not advance. Only after a 0 is sampled are the next seven bits taken as the rest of the command.
- R3: Command bit 6 = 0 selects a write, and bits 5..3 give the address. Bit 2 (0 for writes and ordinary reads) sets continuous-read mode, and bits 1..0 are sent as 0. The data that follows is 16 bits for addresses 1 and 2, 24 bits for 6 and 7, and 8 bits for 5. On the last bit, one write strobe carries the address and the received value.
- R4: Command bit 6 = 1 selects a read. The addressed register is shifted out MSB first, with output changes on falling clock edges and input samples on rising edges. Its width is 8 bits for addresses 0, 4 and 5, 16 bits for 1 and 2, and 24 bits for 3, 6 and 7.
- R5: A write to address 0 is taken as a further command byte and has no data phase. Writes to the read-only addresses 3 and 4 are clocked in fully but raise no write strobe.
- R6: Finishing a read of address 3 (the result register) raises a one-cycle result-taken pulse. Reads of other addresses raise none.
- R7: Command byte 0x5C enters continuous-read mode. Each following group of 24 clocks shifts out the current result with no command byte and ends with a result-taken pulse.
- R8: In continuous-read mode, 0x58 on the data input during the first 8 clocks of a group leaves the mode only if a result is available at the eighth clock. It then returns to command decoding with no result-taken pulse. When no result is available the group runs to completion and the mode remains.
- R9: 32 consecutive rising serial clocks with the data input high raise a one-cycle interface-reset pulse. This holds in every state, including continuous-read mode. The controller then leaves continuous-read mode and waits for a command byte.
- R10: Raising select during a data phase abandons the access. No write is committed, and the controller waits for a new command byte.
- R11: The output-enable is low while select is high and high while select is low.
- R12: With select low and no read bit being shifted, the output pin is the inverse of the result-available input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data, or inverted result-available flag |
| dout_en | output | 1 | Drive enable for the output pin |
| result_ready | input | 1 | High when a new result is available |
| rf_addr | output | 3 | Register address presented to the register file |
| rf_rdata | input | 24 | Register contents for rf_addr, right-aligned |
| rf_wdata | output | 24 | Write data, right-aligned to the register width |
| rf_we | output | 1 | One-cycle write strobe |
| result_taken | output | 1 | One-cycle pulse after a result has been shifted out |
| if_reset | output | 1 | One-cycle pulse asking the register file to reload defaults |

## Verification
The hardest case to reach is the exit from continuous-read mode. The exit byte only has effect when it arrives in the first eight clocks of a streamed group while a result is available. The same byte sent with no result available must be ignored, and the group must stream to the end. The stimulus enters the mode and sends the exit pattern once with the ready input low and once with it high. It then sends an ordinary register read, which only returns the right value if the mode was really left. A second hard case is the run of 32 ones inside a streamed group: it crosses a group boundary and must still reset the interface.

// File: rtl/srp_pkg.sv
package srp_pkg;

  localparam int WORD_W = 24;
  localparam int CNT_W  = 5;

  localparam logic [2:0] ADDR_RESULT = 3'd3;
  localparam logic [7:0] CMD_EXIT_CR = 8'h58;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_LOAD,
    ST_WR,
    ST_RD,
    ST_CR_IDLE,
    ST_CR_RUN
  } srp_state_t;

  // Register width in bits for a given address.
  function automatic logic [CNT_W-1:0] reg_len(input logic [2:0] a);
    case (a)
      3'd1, 3'd2:       return CNT_W'(16);
      3'd3, 3'd6, 3'd7: return CNT_W'(24);
      default:          return CNT_W'(8);
    endcase
  endfunction

  // Addresses whose write data is committed.
  function automatic logic reg_writable(input logic [2:0] a);
    return (a == 3'd1) || (a == 3'd2) || (a == 3'd5) || (a == 3'd6) || (a == 3'd7);
  endfunction

  // Move a right-aligned value of n bits up to the MSB end.
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] d,
                                                   input logic [CNT_W-1:0] n);
    return d << (WORD_W - int'(n));
  endfunction

  // Mask keeping the low n bits.
  function automatic logic [WORD_W-1:0] width_mask(input logic [CNT_W-1:0] n);
    return {WORD_W{1'b1}} >> (WORD_W - int'(n));
  endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic din_i,
  input  logic cs_n_i,
  output logic s_din,
  output logic s_cs_n,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [STAGES-1:0] p_sclk, p_din, p_cs;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sclk <= '1;
      p_din  <= '0;
      p_cs   <= '1;
      sclk_d <= 1'b1;
    end else begin
      p_sclk <= {p_sclk[STAGES-2:0], sclk_i};
      p_din  <= {p_din[STAGES-2:0], din_i};
      p_cs   <= {p_cs[STAGES-2:0], cs_n_i};
      sclk_d <= p_sclk[STAGES-1];
    end
  end

  assign s_din     = p_din[STAGES-1];
  assign s_cs_n    = p_cs[STAGES-1];
  assign sclk_rise = p_sclk[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~p_sclk[STAGES-1] & sclk_d;
endmodule

// File: rtl/srp_ones.sv
module srp_ones #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic din,
  input  logic cs_n,
  output logic hit
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] run;

  assign hit = rise & ~cs_n & din & (run == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run <= '0;
    else if (cs_n || hit)  run <= '0;
    else if (rise)         run <= din ? run + 1'b1 : '0;
  end
endmodule

// File: rtl/srp_engine.sv
module srp_engine
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              s_din,
  input  logic              s_cs_n,
  input  logic              soft_rst,
  input  logic              result_ready,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [2:0]        rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              result_taken,
  output logic              reading,
  output logic              cmd_idle,
  output logic              dout_bit
);
  srp_state_t        state;
  logic [CNT_W-1:0]  cnt, len;
  logic [WORD_W-1:0] sh, rx, nxt_rx;
  logic              cr_mode;
  logic [7:0]        cmd;
  logic              rise, fall, last;

  assign rise     = sclk_rise & ~s_cs_n;
  assign fall     = sclk_fall & ~s_cs_n;
  assign nxt_rx   = {rx[WORD_W-2:0], s_din};
  assign cmd      = nxt_rx[7:0];
  assign last     = (cnt == len - 1'b1);
  assign cmd_idle = (state == ST_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD; cnt <= '0; len <= CNT_W'(8); sh <= '0; rx <= '0;
      cr_mode <= 1'b0; rf_addr <= '0; rf_wdata <= '0; rf_we <= 1'b0;
      result_taken <= 1'b0; reading <= 1'b0; dout_bit <= 1'b1;
    end else if (soft_rst) begin
      state <= ST_CMD; cnt <= '0; len <= CNT_W'(8); sh <= '0; rx <= '0;
      cr_mode <= 1'b0; rf_addr <= '0; rf_we <= 1'b0;
      result_taken <= 1'b0; reading <= 1'b0;
    end else begin
      rf_we        <= 1'b0;
      result_taken <= 1'b0;
      if (s_cs_n) begin
        state   <= cr_mode ? ST_CR_IDLE : ST_CMD;
        cnt     <= '0;
        reading <= 1'b0;
      end else begin
        case (state)
          ST_CMD: begin
            if (rise && !(cnt == '0 && s_din)) begin
              rx <= nxt_rx;
              if (cnt == CNT_W'(7)) begin
                cnt     <= '0;
                rf_addr <= cmd[5:3];
                len     <= reg_len(cmd[5:3]);
                if (cmd[6]) begin
                  if (cmd[2] && cmd[5:3] == ADDR_RESULT) begin
                    cr_mode <= 1'b1;
                    state   <= ST_CR_IDLE;
                  end else begin
                    state <= ST_LOAD;
                  end
                end else if (cmd[5:3] != 3'd0) begin
                  state <= ST_WR;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_LOAD: begin
            sh    <= left_align(rf_rdata, len);
            state <= ST_RD;
          end
          ST_RD: begin
            if (fall) begin
              dout_bit <= sh[WORD_W-1];
              sh       <= sh << 1;
              reading  <= 1'b1;
            end
            if (rise) begin
              if (last) begin
                state        <= ST_CMD;
                cnt          <= '0;
                reading      <= 1'b0;
                result_taken <= (rf_addr == ADDR_RESULT);
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_WR: begin
            if (rise) begin
              rx <= nxt_rx;
              if (last) begin
                state <= ST_CMD;
                cnt   <= '0;
                if (reg_writable(rf_addr)) begin
                  rf_we    <= 1'b1;
                  rf_wdata <= nxt_rx & width_mask(len);
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_CR_IDLE: begin
            sh <= rf_rdata;
            if (fall) begin
              dout_bit <= rf_rdata[WORD_W-1];
              sh       <= rf_rdata << 1;
              reading  <= 1'b1;
              cnt      <= '0;
              state    <= ST_CR_RUN;
            end
          end
          ST_CR_RUN: begin
            if (fall) begin
              dout_bit <= sh[WORD_W-1];
              sh       <= sh << 1;
            end
            if (rise) begin
              rx <= nxt_rx;
              if (cnt == CNT_W'(7) && cmd == CMD_EXIT_CR && result_ready) begin
                cr_mode <= 1'b0;
                state   <= ST_CMD;
                reading <= 1'b0;
                cnt     <= '0;
              end else if (cnt == CNT_W'(WORD_W - 1)) begin
                state        <= ST_CR_IDLE;
                reading      <= 1'b0;
                cnt          <= '0;
                result_taken <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= ST_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ONES_RUN    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic              result_ready,
  output logic [2:0]        rf_addr,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              result_taken,
  output logic              if_reset
);
  logic s_din, s_cs_n, sclk_rise, sclk_fall;
  logic reading, cmd_idle, dout_bit;

  srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .din_i(din), .cs_n_i(cs_n),
    .s_din(s_din), .s_cs_n(s_cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  srp_ones #(.RUN(ONES_RUN)) u_ones (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .din(s_din), .cs_n(s_cs_n),
    .hit(if_reset)
  );

  srp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .s_din(s_din), .s_cs_n(s_cs_n), .soft_rst(if_reset), .result_ready(result_ready),
    .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .result_taken(result_taken), .reading(reading), .cmd_idle(cmd_idle),
    .dout_bit(dout_bit)
  );

  assign dout_en = ~s_cs_n;
  assign dout    = reading ? dout_bit : ~result_ready;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_cs_n,
  input logic       rf_we,
  input logic [2:0] rf_addr,
  input logic       result_taken,
  input logic       if_reset,
  input logic       reading,
  input logic       cmd_idle
);
  // R5: no strobe ever reaches a command, result or identification address
  assert_ro_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr != 3'd0 && rf_addr != 3'd3 && rf_addr != 3'd4));

  // R10: select held high blocks any commit
  assert_abort_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs_n && $past(s_cs_n)) |-> !rf_we);

  // R6: result pulse lasts one cycle
  assert_taken_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_taken |=> !result_taken);

  // R9: after the ones-run reset the engine waits for a command, not shifting
  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |=> (cmd_idle && !reading));

  // R9: events never overlap
  assert_events_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, result_taken, if_reset}));

  // R4: read bits are never shifted while waiting for a command
  assert_read_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reading && cmd_idle));
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs_n(s_cs_n), .rf_we(rf_we), .rf_addr(rf_addr),
  .result_taken(result_taken), .if_reset(if_reset), .reading(reading),
  .cmd_idle(cmd_idle)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
  localparam int H     = 8;
  localparam int LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic        dout, dout_en, result_ready = 1'b0;
  logic [2:0]  rf_addr;
  logic [23:0] rf_rdata, rf_wdata, res_val = 24'h000000;
  logic        rf_we, result_taken, if_reset;

  logic [23:0] mem [8];
  logic [23:0] expv [8];
  int checks = 0, errors = 0, we_cnt = 0, taken_cnt = 0, rst_cnt = 0, cyc = 0;
  logic [2:0]  last_addr;
  logic [23:0] last_data;
  bit          done = 0;

  always #5 clk = ~clk;

  serial_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .dout_en(dout_en), .result_ready(result_ready), .rf_addr(rf_addr),
    .rf_rdata(rf_rdata), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .result_taken(result_taken), .if_reset(if_reset)
  );

  function automatic logic [23:0] dflt(input int a);
    case (a)
      0: return 24'h000088;  1: return 24'h00000A;  2: return 24'h000710;
      4: return 24'h000059;  6: return 24'h800000;  7: return 24'h500000;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic int bits_of(input int a);
    if (a == 1 || a == 2) return 16;
    if (a == 3 || a >= 6) return 24;
    return 8;
  endfunction

  function automatic logic [7:0] cmd_byte(input bit rd, input int a, input bit cr);
    return {1'b0, rd, 3'(a), cr, 2'b00};
  endfunction

  assign rf_rdata = (rf_addr == 3'd3) ? res_val : mem[rf_addr];

  always @(posedge clk) begin
    if (!rst_n || if_reset) begin
      for (int i = 0; i < 8; i++) mem[i] <= dflt(i);
    end else if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
    end
    if (rst_n) begin
      if (rf_we) begin we_cnt <= we_cnt + 1; last_addr <= rf_addr; last_data <= rf_wdata; end
      if (result_taken) taken_cnt <= taken_cnt + 1;
      if (if_reset) rst_cnt <= rst_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic shift_bits(input int n, input logic [31:0] wv, output logic [31:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; din = wv[i];
      repeat (H) @(negedge clk);
      rv[i] = dout;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    din = 1'b0;
  endtask

  task automatic wr_reg(input int a, input logic [23:0] d);
    logic [31:0] dummy;
    shift_bits(8, {24'h0, cmd_byte(1'b0, a, 1'b0)}, dummy);
    if (a != 0) shift_bits(bits_of(a), {8'h0, d}, dummy);
  endtask

  task automatic rd_reg(input int a, output logic [23:0] v);
    logic [31:0] dummy, r;
    shift_bits(8, {24'h0, cmd_byte(1'b1, a, 1'b0)}, dummy);
    shift_bits(bits_of(a), 32'h0, r);
    v = r[23:0];
  endtask

  initial begin
    logic [23:0] v, d;
    logic [31:0] r;
    int a, w0, t0, rs0;
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 8; i++) expv[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 / R11: idle after reset, pin not driven while deselected
    check(dout_en == 1'b0, "R11 dout_en with cs high", dout_en, 0);
    check(we_cnt == 0 && taken_cnt == 0 && rst_cnt == 0, "R1 no events after reset",
          we_cnt + taken_cnt + rst_cnt, 0);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    check(dout_en == 1'b1, "R11 dout_en with cs low", dout_en, 1);
    // R12: pin mirrors inverted ready
    check(dout == 1'b1, "R12 pin with no result", dout, 1);
    result_ready = 1'b1; repeat (2) @(negedge clk);
    check(dout == 1'b0, "R12 pin with result", dout, 0);
    result_ready = 1'b0;

    // R1: first command decoded directly
    rd_reg(4, v);
    check(v == expv[4], "R1 first command read id", v, expv[4]);

    // R2: leading ones hold the start position
    shift_bits(3, 32'h7, r);
    rd_reg(4, v);
    check(v == expv[4], "R2 start bit stall", v, expv[4]);

    // R3 / R4: random writes and readbacks over writable addresses
    for (int k = 0; k < 16; k++) begin
      case ($urandom % 5)
        0: a = 1; 1: a = 2; 2: a = 5; 3: a = 6; default: a = 7;
      endcase
      d = 24'($urandom) & 24'((1 << bits_of(a)) - 1);
      w0 = we_cnt;
      wr_reg(a, d);
      repeat (2) @(negedge clk);
      check(we_cnt == w0 + 1 && last_addr == 3'(a) && last_data == d,
            "R3 write strobe data", {5'd0, last_addr, last_data}, {5'd0, 3'(a), d});
      expv[a] = d;
      rd_reg(a, v);
      check(v == expv[a], "R4 readback", v, expv[a]);
    end

    // R5: read-only and command addresses discard writes
    w0 = we_cnt;
    wr_reg(4, 24'h0000A5);
    wr_reg(3, 24'h123456);
    wr_reg(0, 24'h0);
    repeat (2) @(negedge clk);
    check(we_cnt == w0, "R5 no strobe for read-only", we_cnt, w0);
    rd_reg(4, v);
    check(v == expv[4], "R5 id unchanged", v, expv[4]);
    rd_reg(0, v);
    check(v == expv[0], "R5 status read after addr-0 write", v, expv[0]);

    // R6: result read pulses, others do not
    res_val = 24'hC3A51E;
    t0 = taken_cnt;
    rd_reg(3, v);
    repeat (2) @(negedge clk);
    check(v == 24'hC3A51E, "R6 result value", v, 24'hC3A51E);
    check(taken_cnt == t0 + 1, "R6 taken after result read", taken_cnt, t0 + 1);
    rd_reg(1, v);
    repeat (2) @(negedge clk);
    check(taken_cnt == t0 + 1, "R6 no taken after other read", taken_cnt, t0 + 1);

    // R7: continuous read streams two results
    shift_bits(8, 32'h5C, r);
    res_val = 24'h0F1E2D;
    t0 = taken_cnt;
    shift_bits(24, 32'h0, r);
    check(r[23:0] == 24'h0F1E2D, "R7 first streamed result", r, 24'h0F1E2D);
    res_val = 24'hB4C3D2;
    shift_bits(24, 32'h0, r);
    repeat (2) @(negedge clk);
    check(r[23:0] == 24'hB4C3D2, "R7 second streamed result", r, 24'hB4C3D2);
    check(taken_cnt == t0 + 2, "R7 taken per group", taken_cnt, t0 + 2);

    // R8: exit byte ignored without a result, honoured with one
    result_ready = 1'b0;
    res_val = 24'h777111;
    shift_bits(24, 32'h580000, r);
    check(r[23:0] == 24'h777111, "R8 exit ignored while not ready", r, 24'h777111);
    result_ready = 1'b1;
    t0 = taken_cnt;
    shift_bits(8, 32'h58, r);
    repeat (2) @(negedge clk);
    check(taken_cnt == t0, "R8 no taken on exit", taken_cnt, t0);
    result_ready = 1'b0;
    rd_reg(4, v);
    check(v == expv[4], "R8 command decoding after exit", v, expv[4]);

    // R9: 32 ones reset, both from command wait and inside continuous read
    wr_reg(1, 24'h00BEEF);
    rs0 = rst_cnt;
    shift_bits(32, 32'hFFFFFFFF, r);
    repeat (2) @(negedge clk);
    check(rst_cnt == rs0 + 1, "R9 reset pulse", rst_cnt, rs0 + 1);
    for (int i = 0; i < 8; i++) expv[i] = dflt(i);
    rd_reg(1, v);
    check(v == expv[1], "R9 defaults after reset", v, expv[1]);
    shift_bits(8, 32'h5C, r);
    shift_bits(32, 32'hFFFFFFFF, r);
    repeat (2) @(negedge clk);
    check(rst_cnt == rs0 + 2, "R9 reset inside continuous read", rst_cnt, rs0 + 2);
    rd_reg(4, v);
    check(v == expv[4], "R9 continuous read left", v, expv[4]);

    // R10: select rise mid-write abandons it
    w0 = we_cnt;
    shift_bits(8, {24'h0, cmd_byte(1'b0, 2, 1'b0)}, r);
    shift_bits(10, 32'h3FF, r);
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
    check(dout_en == 1'b0, "R11 released on abort", dout_en, 0);
    check(we_cnt == w0, "R10 no strobe after abort", we_cnt, w0);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    rd_reg(2, v);
    check(v == expv[2], "R10 register kept", v, expv[2]);

    done = 1;
    summary();
    $finish;
  end
endmodule